// File: doc/BRIEF.md
# Qualified Edge Condition Detector

This block watches the two lines of a synchronous serial link: a clock-like line and a data line. It reports two events. The first is a falling transition of the clock line while the data line is high. The second is a rising transition of the clock line while the data line is high. Both lines are asynchronous to the system clock, so each one passes through a synchronizer before any edge is looked for. The data level that qualifies an edge is the synchronized data value in the same cycle that the edge is seen.

Each event has a sticky status bit behind a read-only register on a small bus with an address, a write strobe, a read strobe and read data. Software can poll these registers. A write strobe to a register's address clears its bit, and the bus carries no write data because the value written does not matter. Each event also drives its own one-cycle interrupt pulse. An enable input gates both the status bits and the interrupts. Detection depends on no other mode setting.

Top module: `edge_cond_detector`

## Requirements
- R1: A falling transition of `lineClk` while `lineData` is high sets the fall status bit and pulses `irqFall`. After a line change is presented before clock edge k, both become visible after edge k+2.
- R2: A rising transition of `lineClk` while `lineData` is high sets the rise status bit and pulses `irqRise`, with the same latency as R1.
- R3: A transition of `lineClk` while `lineData` is low sets no status bit and raises no interrupt.
- R4: While `enable` is low, no transition sets a status bit or raises an interrupt.
- R5: A status bit stays set until it is cleared. A read has no effect on it.
- R6: A write strobe with `busAddr` equal to `FALL_ADDR` (default 0x0) clears only the fall bit. One with `busAddr` equal to `RISE_ADDR` (default 0x1) clears only the rise bit. The clear takes effect at the clock edge that samples the strobe.
- R7: If a detection and a clearing write to the same bit meet at the same clock edge, the bit ends up set.
- R8: Each interrupt is high for exactly one clock cycle per detection.
- R9: While `busRd` is high, `busRdata` carries the addressed status bit in bit 0 and zero in every other bit. It is all zeros when `busRd` is low or the address matches neither register.
- R10: Reset clears both status bits. Line transitions seen in the first three clock cycles after reset are not reported.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Asynchronous active-low reset |
| enable | input | 1 | Interface enable; gates all detection |
| lineClk | input | 1 | Asynchronous serial clock line |
| lineData | input | 1 | Asynchronous serial data line |
| busAddr | input | ADDR_W | Register address |
| busWr | input | 1 | Write strobe; clears the addressed status bit |
| busRd | input | 1 | Read strobe |
| busRdata | output | DATA_W | Read data, combinational from address and strobe |
| irqFall | output | 1 | One-cycle pulse per falling-edge detection |
| irqRise | output | 1 | One-cycle pulse per rising-edge detection |

## Verification
The assertions assume that the two register addresses differ. They also assume that the clock line cannot produce two edges of the same direction in consecutive cycles, which follows from the synchronizer. The enable check assumes `enable` is driven synchronously. The stimulus changes the lines only at falling system-clock edges and holds every line level for at least three cycles, so each transition is seen exactly once. Enable changes and bus strobes come only from the same synchronous tasks.

// File: rtl/edge_cond_pkg.sv
package edge_cond_pkg;

  // Edge events produced by the datapath after synchronization.
  typedef struct packed {
    logic fall;
    logic rise;
    logic dataHigh;
  } line_events_t;

  // Strobes from control to datapath.
  typedef struct packed {
    logic setFall;
    logic setRise;
    logic clrFall;
    logic clrRise;
    logic selFall;
    logic selRise;
  } ctrl_strobes_t;

endpackage

// File: rtl/edge_cond_sync.sv
module edge_cond_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rstN,
  input  logic d,
  output logic q
);
  logic [STAGES-1:0] chain;

  generate
    if (STAGES == 1) begin : g_single
      always_ff @(posedge clk or negedge rstN) begin
        if (!rstN) chain <= '0;
        else       chain <= d;
      end
    end else begin : g_multi
      always_ff @(posedge clk or negedge rstN) begin
        if (!rstN) chain <= '0;
        else       chain <= {chain[STAGES-2:0], d};
      end
    end
  endgenerate

  assign q = chain[STAGES-1];
endmodule

// File: rtl/edge_cond_datapath.sv
module edge_cond_datapath
  import edge_cond_pkg::*;
#(
  parameter int SYNC_STAGES = 2,
  parameter int DATA_W      = 8
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic                lineClk,
  input  logic                lineData,
  input  ctrl_strobes_t       strobes,
  output line_events_t        events,
  output logic                statusFall,
  output logic                statusRise,
  output logic                irqFall,
  output logic                irqRise,
  output logic [DATA_W-1:0]   busRdata
);
  localparam int PRIME_W = SYNC_STAGES + 1;

  logic clkSync, dataSync, clkPrev;
  logic [PRIME_W-1:0] primeSr;
  logic primed;

  edge_cond_sync #(.STAGES(SYNC_STAGES)) clkSync_i (
    .clk(clk), .rstN(rstN), .d(lineClk), .q(clkSync)
  );
  edge_cond_sync #(.STAGES(SYNC_STAGES)) dataSync_i (
    .clk(clk), .rstN(rstN), .d(lineData), .q(dataSync)
  );

  // Previous clock-line sample and a fill marker that stays low
  // until the synchronizer and the previous sample hold real data.
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      clkPrev <= 1'b0;
      primeSr <= '0;
    end else begin
      clkPrev <= clkSync;
      primeSr <= {primeSr[PRIME_W-2:0], 1'b1};
    end
  end

  assign primed          = primeSr[PRIME_W-1];
  assign events.fall     = primed & clkPrev & ~clkSync;
  assign events.rise     = primed & ~clkPrev & clkSync;
  assign events.dataHigh = dataSync;

  // Sticky status: set beats clear.
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      statusFall <= 1'b0;
      statusRise <= 1'b0;
      irqFall    <= 1'b0;
      irqRise    <= 1'b0;
    end else begin
      irqFall <= strobes.setFall;
      irqRise <= strobes.setRise;
      if (strobes.setFall)      statusFall <= 1'b1;
      else if (strobes.clrFall) statusFall <= 1'b0;
      if (strobes.setRise)      statusRise <= 1'b1;
      else if (strobes.clrRise) statusRise <= 1'b0;
    end
  end

  always_comb begin
    busRdata = '0;
    if (strobes.selFall)      busRdata[0] = statusFall;
    else if (strobes.selRise) busRdata[0] = statusRise;
  end
endmodule

// File: rtl/edge_cond_ctrl.sv
module edge_cond_ctrl
  import edge_cond_pkg::*;
#(
  parameter int          ADDR_W    = 4,
  parameter logic [ADDR_W-1:0] FALL_ADDR = 'h0,
  parameter logic [ADDR_W-1:0] RISE_ADDR = 'h1
) (
  input  logic              enable,
  input  logic [ADDR_W-1:0] busAddr,
  input  logic              busWr,
  input  logic              busRd,
  input  line_events_t      events,
  output ctrl_strobes_t     strobes
);
  logic hitFall, hitRise, qualified;

  assign hitFall   = (busAddr == FALL_ADDR);
  assign hitRise   = (busAddr == RISE_ADDR);
  assign qualified = enable & events.dataHigh;

  always_comb begin
    strobes.setFall = qualified & events.fall;
    strobes.setRise = qualified & events.rise;
    strobes.clrFall = busWr & hitFall;
    strobes.clrRise = busWr & hitRise;
    strobes.selFall = busRd & hitFall;
    strobes.selRise = busRd & hitRise;
  end
endmodule

// File: rtl/edge_cond_detector.sv
module edge_cond_detector
  import edge_cond_pkg::*;
#(
  parameter int                ADDR_W      = 4,
  parameter int                DATA_W      = 8,
  parameter int                SYNC_STAGES = 2,
  parameter logic [ADDR_W-1:0] FALL_ADDR   = 'h0,
  parameter logic [ADDR_W-1:0] RISE_ADDR   = 'h1
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              enable,
  input  logic              lineClk,
  input  logic              lineData,
  input  logic [ADDR_W-1:0] busAddr,
  input  logic              busWr,
  input  logic              busRd,
  output logic [DATA_W-1:0] busRdata,
  output logic              irqFall,
  output logic              irqRise
);
  line_events_t  events;
  ctrl_strobes_t strobes;
  logic          statusFall, statusRise;

  edge_cond_ctrl #(
    .ADDR_W(ADDR_W), .FALL_ADDR(FALL_ADDR), .RISE_ADDR(RISE_ADDR)
  ) ctrl_i (
    .enable(enable), .busAddr(busAddr), .busWr(busWr), .busRd(busRd),
    .events(events), .strobes(strobes)
  );

  edge_cond_datapath #(
    .SYNC_STAGES(SYNC_STAGES), .DATA_W(DATA_W)
  ) dp_i (
    .clk(clk), .rstN(rstN), .lineClk(lineClk), .lineData(lineData),
    .strobes(strobes), .events(events),
    .statusFall(statusFall), .statusRise(statusRise),
    .irqFall(irqFall), .irqRise(irqRise), .busRdata(busRdata)
  );
endmodule

// File: rtl/edge_cond_checker.sv
module edge_cond_checker #(
  parameter int                ADDR_W    = 4,
  parameter int                DATA_W    = 8,
  parameter logic [ADDR_W-1:0] FALL_ADDR = 'h0,
  parameter logic [ADDR_W-1:0] RISE_ADDR = 'h1
) (
  input logic              clk,
  input logic              rstN,
  input logic              enable,
  input logic [ADDR_W-1:0] busAddr,
  input logic              busWr,
  input logic              busRd,
  input logic [DATA_W-1:0] busRdata,
  input logic              statusFall,
  input logic              statusRise,
  input logic              irqFall,
  input logic              irqRise
);
  // R1/R2: an interrupt comes with its status bit set
  a_r1_irq_sets_fall: assert property (@(posedge clk) disable iff (!rstN)
    irqFall |-> statusFall);
  a_r2_irq_sets_rise: assert property (@(posedge clk) disable iff (!rstN)
    irqRise |-> statusRise);
  // R4: enable low blocks the next interrupts
  a_r4_disabled_quiet: assert property (@(posedge clk) disable iff (!rstN)
    !enable |=> (!irqFall && !irqRise));
  // R5: sticky without a clearing write
  a_r5_sticky_fall: assert property (@(posedge clk) disable iff (!rstN)
    (statusFall && !(busWr && busAddr == FALL_ADDR)) |=> statusFall);
  a_r5_sticky_rise: assert property (@(posedge clk) disable iff (!rstN)
    (statusRise && !(busWr && busAddr == RISE_ADDR)) |=> statusRise);
  // R6/R7: a clearing write leaves the bit low unless a detection wins
  a_r6_clear_fall: assert property (@(posedge clk) disable iff (!rstN)
    (busWr && busAddr == FALL_ADDR) |=> (!statusFall || irqFall));
  a_r6_clear_rise: assert property (@(posedge clk) disable iff (!rstN)
    (busWr && busAddr == RISE_ADDR) |=> (!statusRise || irqRise));
  // R8: single-cycle pulses
  a_r8_fall_pulse: assert property (@(posedge clk) disable iff (!rstN)
    irqFall |=> !irqFall);
  a_r8_rise_pulse: assert property (@(posedge clk) disable iff (!rstN)
    irqRise |=> !irqRise);
  // R9: upper read bits zero, idle bus reads zero
  a_r9_upper_zero: assert property (@(posedge clk) disable iff (!rstN)
    busRdata[DATA_W-1:1] == '0);
  a_r9_idle_zero: assert property (@(posedge clk) disable iff (!rstN)
    !busRd |-> (busRdata == '0));
endmodule

bind edge_cond_detector edge_cond_checker #(
  .ADDR_W(ADDR_W), .DATA_W(DATA_W), .FALL_ADDR(FALL_ADDR), .RISE_ADDR(RISE_ADDR)
) chk_i (
  .clk(clk), .rstN(rstN), .enable(enable), .busAddr(busAddr), .busWr(busWr),
  .busRd(busRd), .busRdata(busRdata), .statusFall(statusFall),
  .statusRise(statusRise), .irqFall(irqFall), .irqRise(irqRise)
);

// File: tb/edge_cond_detector_tb_top.sv
module edge_cond_detector_tb_top;
  localparam int ADDR_W = 4;
  localparam int DATA_W = 8;
  localparam logic [ADDR_W-1:0] FA = 4'h0;
  localparam logic [ADDR_W-1:0] RA = 4'h1;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic enable = 1'b0, lineClk = 1'b0, lineData = 1'b0;
  logic [ADDR_W-1:0] busAddr = '0;
  logic busWr = 1'b0, busRd = 1'b0;
  logic [DATA_W-1:0] busRdata;
  logic irqFall, irqRise;

  int checks = 0, fails = 0;
  int expQ[$];   // 1 = fall event, 2 = rise event
  logic prevFall = 1'b0, prevRise = 1'b0;

  always #5 clk = ~clk;

  edge_cond_detector #(.ADDR_W(ADDR_W), .DATA_W(DATA_W),
                       .FALL_ADDR(FA), .RISE_ADDR(RA)) dut_i (
    .clk(clk), .rstN(rstN), .enable(enable), .lineClk(lineClk),
    .lineData(lineData), .busAddr(busAddr), .busWr(busWr), .busRd(busRd),
    .busRdata(busRdata), .irqFall(irqFall), .irqRise(irqRise)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // Monitor: pops expected events as interrupts appear (R1, R2, R8).
  always @(negedge clk) begin
    if (rstN) begin
      if (irqFall || irqRise) begin
        int got;
        got = irqFall ? 1 : 2;
        if (expQ.size() == 0) check("R3/R4 unexpected irq", got, 0);
        else check("R1/R2 irq kind", got, expQ.pop_front());
      end
      if (prevFall && irqFall) check("R8 fall pulse width", 2, 1);
      if (prevRise && irqRise) check("R8 rise pulse width", 2, 1);
    end
    prevFall <= irqFall;
    prevRise <= irqRise;
  end

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  // Driver: changes lines and pushes the expected event.
  task automatic drive(input logic c, input logic d);
    @(negedge clk);
    if (enable && d && lineClk && !c) expQ.push_back(1);
    if (enable && d && !lineClk && c) expQ.push_back(2);
    lineClk = c;
    lineData = d;
  endtask

  task automatic settle();
    tick(4);
  endtask

  task automatic rd(input logic [ADDR_W-1:0] a, input logic [DATA_W-1:0] exp, input string req);
    @(negedge clk);
    busAddr = a; busRd = 1'b1;
    #1 check(req, busRdata, exp);
    @(negedge clk);
    busRd = 1'b0;
  endtask

  task automatic wr(input logic [ADDR_W-1:0] a);
    @(negedge clk);
    busAddr = a; busWr = 1'b1;
    @(negedge clk);
    busWr = 1'b0;
  endtask

  initial begin : watchdog
    repeat (200000) @(posedge clk);
    check("watchdog expired", 1, 0);
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    tick(3);
    rstN = 1'b1;
    // R10: reset state, R9 idle read
    #1 check("R9 idle bus zero", busRdata, 0);
    rd(FA, 0, "R10 fall bit after reset");
    rd(RA, 0, "R10 rise bit after reset");
    enable = 1'b1;
    tick(2);

    // R3: transitions with data low
    drive(1, 0); settle();
    drive(0, 0); settle();
    rd(FA, 0, "R3 fall ignored with data low");
    rd(RA, 0, "R3 rise ignored with data low");

    // R2 then R1
    drive(0, 1); settle();
    drive(1, 1);
    tick(2);
    check("R2 irqRise before latency", irqRise, 0);
    tick(1);
    check("R2 irqRise at latency", irqRise, 1);
    tick(1);
    rd(RA, 1, "R2 rise bit set");
    rd(FA, 0, "R2 fall bit untouched");
    drive(0, 1); settle();
    rd(FA, 1, "R1 fall bit set");
    // R5: reads do not clear
    rd(FA, 1, "R5 fall bit survives read");
    // R9: unmapped address reads zero
    rd(4'h7, 0, "R9 unmapped address");

    // R6: clears only the addressed bit
    wr(FA);
    rd(FA, 0, "R6 fall bit cleared");
    rd(RA, 1, "R6 rise bit kept");
    wr(RA);
    rd(RA, 0, "R6 rise bit cleared");

    // R4: disabled
    enable = 1'b0;
    drive(1, 1); settle();
    drive(0, 1); settle();
    rd(FA, 0, "R4 fall blocked when disabled");
    rd(RA, 0, "R4 rise blocked when disabled");
    enable = 1'b1;

    // R7: detection and clear in the same cycle
    drive(1, 1); settle();
    wr(RA);
    rd(RA, 0, "R7 setup rise cleared");
    drive(0, 1);
    tick(2);
    busAddr = FA; busWr = 1'b1;
    tick(1);
    busWr = 1'b0;
    rd(FA, 1, "R7 set wins over clear");

    // R10: reset clears set bits, no spurious event after reset
    drive(1, 1); settle();
    rd(RA, 1, "R10 setup rise set");
    rstN = 1'b0;
    tick(2);
    rstN = 1'b1;
    tick(5);
    rd(FA, 0, "R10 fall cleared by reset");
    rd(RA, 0, "R10 rise cleared by reset");

    tick(4);
    check("scoreboard drained", expQ.size(), 0);
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule